// File: doc/BRIEF.md
# Floating-Point Issue Gate

This block decides, cycle by cycle, whether a candidate floating-point instruction may leave the decode stage and enter a partially pipelined floating-point unit. Every operation class has two timing figures. The first is the result latency: the number of cycles before a dependent instruction may read the result. The second is the repeat interval: the number of cycles before the next instruction of the same class may start. The gate checks both figures against the candidate. It grants issue only when the class's unit can accept work and none of the candidate's source registers is waiting for an in-flight result.

Pending results are tracked by one down-counter per architectural register. A grant loads the destination's counter with the operation's latency minus one. Each operation class also has its own down-counter, which a grant loads with the repeat interval minus one. Issue is decided combinationally from the current inputs and counter state. A stalled candidate is held by the upstream stage and is presented again on the next cycle. At most one instruction is granted per cycle. The arithmetic pipelines are outside this block.

Top module: `fpi_issue_ctl`

## Requirements
- R1: After a synchronous active-high reset, every bit of `reg_ready` is 1, and a valid request for any class with any registers is granted in the first cycle.
- R2: Class code 0 (add/subtract) has latency 4 and repeat interval 3. A second code-0 request is granted no earlier than 3 cycles after the first. A reader of its destination is granted no earlier than 4 cycles after it.
- R3: Class code 1 (multiply) has latency 8 and repeat interval 4.
- R4: Class code 2 (negate/absolute value) has latency 2 and repeat interval 1. Code-2 requests may be granted on back-to-back cycles.
- R5: Class code 3 (compare) has latency 3 and repeat interval 2.
- R6: A request is structurally stalled (`stall_struct`=1) only while its own class is inside its repeat interval. A request of another class is not affected.
- R7: A request is stalled for a data dependency (`stall_raw`=1) when either `src_a` or `src_b` names a register with a result still pending.
- R8: When `req_valid` is 0, `issue`, `stall_struct` and `stall_raw` are 0, and no counter is loaded.
- R9: Granting an instruction whose destination already has a pending result replaces that register's countdown with the new operation's latency.
- R10: `issue` equals `req_valid` with neither stall flag set. Both stall flags may be 1 in the same cycle.
- R11: `reg_ready[r]` is 0 from the cycle after a grant to register r for latency-1 cycles, then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Candidate instruction present |
| req_op | input | 2 | Operation class code (0 add/sub, 1 mul, 2 neg/abs, 3 compare) |
| req_src_a | input | $clog2(NREG) | First source register |
| req_src_b | input | $clog2(NREG) | Second source register |
| req_dst | input | $clog2(NREG) | Destination register |
| issue | output | 1 | Candidate granted this cycle |
| stall_struct | output | 1 | Candidate blocked by its class's repeat interval |
| stall_raw | output | 1 | Candidate blocked by a pending source result |
| reg_ready | output | NREG | Per-register result-available flags |

## Verification
The assertions check four things on every cycle: a grant loads exactly the expected counts into the register counter and the class counter, an unloaded pending counter only ever falls by one per cycle, a busy class is never fired, and an idle request line never raises grant or stall. Whether those counts match the class table, and the cycle on which a held request is finally granted, can only be seen from the bench's scenarios. The same applies to a destination reload that shortens a countdown and to two stall causes that overlap. The bench checks these against a model of the requirements.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    typedef enum logic [1:0] {
        FOP_ADD = 2'd0,
        FOP_MUL = 2'd1,
        FOP_NEG = 2'd2,
        FOP_CMP = 2'd3
    } fop_e;

    localparam int unsigned FOP_COUNT = 4;
    localparam int unsigned FCNT_W    = 4;

    typedef logic [FCNT_W-1:0] fcnt_t;

    function automatic fcnt_t fop_latency(fop_e op);
        case (op)
            FOP_ADD: return fcnt_t'(4);
            FOP_MUL: return fcnt_t'(8);
            FOP_NEG: return fcnt_t'(2);
            default: return fcnt_t'(3);
        endcase
    endfunction

    function automatic fcnt_t fop_interval(fop_e op);
        case (op)
            FOP_ADD: return fcnt_t'(3);
            FOP_MUL: return fcnt_t'(4);
            FOP_NEG: return fcnt_t'(1);
            default: return fcnt_t'(2);
        endcase
    endfunction

endpackage

// File: rtl/fpi_reg_score.sv
module fpi_reg_score #(
    parameter int unsigned NREG = 32,
    parameter int unsigned CW   = 4,
    localparam int unsigned RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [RW-1:0] load_idx,
    input  logic [CW-1:0] load_val,
    output logic [NREG-1:0] ready
);

    logic [CW-1:0] cnt [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) cnt[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (load_en && (load_idx == RW'(i)))
                    cnt[i] <= load_val;
                else if (cnt[i] != '0)
                    cnt[i] <= cnt[i] - 1'b1;
            end
        end
    end

    // R9: the granted destination holds the supplied count one cycle later
    a_r9_dst_loaded: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cnt[$past(load_idx)] == $past(load_val));

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            assign ready[g] = (cnt[g] == '0);

            // R11: an unloaded pending count falls by exactly one
            a_r11_countdown: assert property (@(posedge clk) disable iff (rst)
                (!(load_en && load_idx == RW'(g)) && cnt[g] != '0)
                    |=> cnt[g] == $past(cnt[g]) - 1'b1);
        end
    endgenerate

endmodule

// File: rtl/fpi_type_gate.sv
module fpi_type_gate #(
    parameter int unsigned NTYPE = 4,
    parameter int unsigned CW    = 4,
    localparam int unsigned TW   = $clog2(NTYPE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [TW-1:0]    fire_type,
    input  logic [CW-1:0]    fire_val,
    output logic [NTYPE-1:0] busy
);

    logic [CW-1:0] cnt [NTYPE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NTYPE; t++) cnt[t] <= '0;
        end else begin
            for (int t = 0; t < NTYPE; t++) begin
                if (fire && (fire_type == TW'(t)))
                    cnt[t] <= fire_val;
                else if (cnt[t] != '0)
                    cnt[t] <= cnt[t] - 1'b1;
            end
        end
    end

    // R6: a grant arms its class counter with the supplied spacing
    a_r6_class_armed: assert property (@(posedge clk) disable iff (rst)
        fire |=> cnt[$past(fire_type)] == $past(fire_val));

    genvar g;
    generate
        for (g = 0; g < NTYPE; g++) begin : g_type
            assign busy[g] = (cnt[g] != '0);

            // R6: a class inside its repeat interval is never fired
            a_r6_busy_no_fire: assert property (@(posedge clk) disable iff (rst)
                busy[g] |-> !(fire && fire_type == TW'(g)));
        end
    endgenerate

endmodule

// File: rtl/fpi_issue_ctl.sv
module fpi_issue_ctl #(
    parameter int unsigned NREG = 32,
    localparam int unsigned RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [RW-1:0]   req_src_a,
    input  logic [RW-1:0]   req_src_b,
    input  logic [RW-1:0]   req_dst,
    output logic            issue,
    output logic            stall_struct,
    output logic            stall_raw,
    output logic [NREG-1:0] reg_ready
);
    import fpi_pkg::*;

    fop_e  op;
    fcnt_t lat;
    fcnt_t ival;
    fcnt_t dst_load;
    fcnt_t type_load;
    logic [FOP_COUNT-1:0] type_busy;

    always_comb begin
        op        = fop_e'(req_op);
        lat       = fop_latency(op);
        ival      = fop_interval(op);
        dst_load  = lat - 1'b1;
        type_load = ival - 1'b1;
    end

    always_comb begin
        stall_struct = req_valid && type_busy[req_op];
        stall_raw    = req_valid && (!reg_ready[req_src_a] || !reg_ready[req_src_b]);
        issue        = req_valid && !stall_struct && !stall_raw;
    end

    fpi_reg_score #(
        .NREG (NREG),
        .CW   (FCNT_W)
    ) u_score (
        .clk      (clk),
        .rst      (rst),
        .load_en  (issue),
        .load_idx (req_dst),
        .load_val (dst_load),
        .ready    (reg_ready)
    );

    fpi_type_gate #(
        .NTYPE (FOP_COUNT),
        .CW    (FCNT_W)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .fire      (issue),
        .fire_type (req_op),
        .fire_val  (type_load),
        .busy      (type_busy)
    );

    // R8: an empty request slot raises neither grant nor stall
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !issue && !stall_struct && !stall_raw);

    // R7: a pending source register forbids a grant
    a_r7_pending_src_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !reg_ready[req_src_a]) |-> !issue);

endmodule

// File: tb/fpi_issue_ctl_bench.sv
`timescale 1ns/100ps
module fpi_issue_ctl_bench;
    localparam int NREG = 32;
    localparam int RW   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [RW-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
    logic issue, stall_struct, stall_raw;
    logic [NREG-1:0] reg_ready;

    always #2.5 clk = ~clk;

    fpi_issue_ctl #(.NREG(NREG)) u_fpi_issue_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
        .issue(issue), .stall_struct(stall_struct), .stall_raw(stall_raw),
        .reg_ready(reg_ready));

    typedef struct {
        string tag;
        bit    iss;
        bit    ss;
        bit    sr;
        logic [NREG-1:0] rdy;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int fails = 0;
    int mrc[NREG];
    int mtc[4];

    // Class table from R2..R5
    function automatic int t_lat(int op);
        case (op) 0: return 4; 1: return 8; 2: return 2; default: return 3; endcase
    endfunction
    function automatic int t_ii(int op);
        case (op) 0: return 3; 1: return 4; 2: return 1; default: return 2; endcase
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NREG; i++) mrc[i] = 0;
        for (int t = 0; t < 4; t++) mtc[t] = 0;
    endtask

    // Driver: present a request, push the expectation, advance the model
    task automatic step(bit v, int op, int a, int b, int d, string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_op = 2'(op);
        req_src_a = RW'(a); req_src_b = RW'(b); req_dst = RW'(d);
        e.tag = tag;
        e.ss  = v && (mtc[op] != 0);
        e.sr  = v && (mrc[a] != 0 || mrc[b] != 0);
        e.iss = v && !e.ss && !e.sr;
        for (int i = 0; i < NREG; i++) e.rdy[i] = (mrc[i] == 0);
        exp_q.push_back(e);
        for (int i = 0; i < NREG; i++) if (mrc[i] != 0) mrc[i]--;
        for (int t = 0; t < 4; t++) if (mtc[t] != 0) mtc[t]--;
        if (e.iss) begin
            mrc[d]  = t_lat(op) - 1;
            mtc[op] = t_ii(op) - 1;
        end
    endtask

    task automatic hold(int n, int op, int a, int b, int d, string tag);
        for (int k = 0; k < n; k++) step(1'b1, op, a, b, d, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare each expectation once the driven inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if ({issue, stall_struct, stall_raw} !== {e.iss, e.ss, e.sr}) begin
                    fails++;
                    $display("FAIL %s: issue/struct/raw actual %b%b%b expected %b%b%b",
                             e.tag, issue, stall_struct, stall_raw, e.iss, e.ss, e.sr);
                end
                total++;
                if (reg_ready !== e.rdy) begin
                    fails++;
                    $display("FAIL %s R11: reg_ready actual %h expected %h",
                             e.tag, reg_ready, e.rdy);
                end
            end
        end
    end

    initial begin
        #100000;
        total++; fails++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then immediate grant of a multiply
        idle(1, "R1 idle after reset");
        step(1'b1, 1, 30, 31, 20, "R1 first request granted");
        idle(9, "R8 idle drain");
        // R2: add spacing 3, dependent reader waits 4
        step(1'b1, 0, 2, 3, 1, "R2 add issue");
        hold(3, 0, 5, 6, 4, "R2 second add spacing");
        hold(2, 0, 1, 7, 8, "R2 add reader of r1");
        idle(4, "R8 idle");
        // R6: other classes unaffected by a busy add unit
        step(1'b1, 0, 2, 3, 9, "R6 add arms class");
        step(1'b1, 1, 2, 3, 10, "R6 mul during add busy");
        step(1'b1, 2, 2, 3, 11, "R6 neg during add busy");
        idle(8, "R8 idle");
        // R3: multiply interval 4, reader waits 8
        step(1'b1, 1, 2, 3, 7, "R3 mul issue");
        hold(4, 1, 4, 5, 12, "R3 second mul spacing");
        hold(5, 3, 2, 7, 13, "R3 R7 cmp reader of r7 via src_b");
        idle(9, "R8 idle");
        // R4: back-to-back negates, reader after 2
        step(1'b1, 2, 2, 3, 14, "R4 neg issue");
        step(1'b1, 2, 4, 5, 15, "R4 neg back to back");
        step(1'b1, 2, 14, 14, 16, "R4 neg reader of r14");
        idle(3, "R8 idle");
        // R5: compare interval 2, latency 3
        step(1'b1, 3, 2, 3, 17, "R5 cmp issue");
        hold(2, 3, 4, 5, 18, "R5 second cmp spacing");
        hold(3, 0, 17, 2, 19, "R5 R7 add reader of r17 via src_a");
        idle(5, "R8 idle");
        // R10: both stall causes together
        step(1'b1, 1, 2, 3, 21, "R10 mul arms");
        hold(4, 1, 21, 3, 22, "R10 struct and raw together");
        idle(9, "R8 idle");
        // R9: reload of a pending destination with a shorter latency
        step(1'b1, 1, 2, 3, 23, "R9 mul to r23");
        step(1'b1, 2, 4, 5, 23, "R9 neg overwrites r23");
        hold(2, 2, 23, 23, 24, "R9 reader of r23 after short latency");
        // R8: an invalid request changes nothing
        step(1'b0, 0, 23, 23, 25, "R8 invalid with pending src");
        idle(3, "R8 idle");
        step(1'b1, 0, 25, 25, 26, "R8 no load from invalid request");
        idle(6, "R8 final drain");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule